// File: doc/BRIEF.md
# Coarse-Fine Time Interval Measurement Controller

This block runs one time-interval measurement after another for a coarse-fine time-to-digital converter in which the start event comes from inside the chip. A free-running generator emits a one-clock start pulse every `START_PERIOD` clocks. Each start pulse clears a coarse cycle counter, which then counts clocks and holds at its maximum value. Because the start pulse is aligned to the clock, the fine start offset is zero. The measured interval is therefore the coarse count times the clock period, minus the fine stop offset that the external encoder reports.

An asynchronous detector hit sets a stop flag, which drives the external delay line. The block registers the output of the first delay cell. When that cell output falls, the same clock edge does three things: it freezes the external fine sample register by dropping its enable, it holds the coarse count, and it starts a write sequencer. The sequencer waits `ENC_LAT` clocks so the external encoder can settle. It then pushes one word, made of the overrange flag, the coarse count and the fine code, into an external FIFO. If the FIFO is full, the word is dropped and a drop counter is advanced instead. Last, the sequencer pulses a re-arm strobe that clears the stop flag. Hits that arrive before the sequencer is idle again have no effect.

Top module: `tdc_meas_ctrl`

## Requirements
- R1: After reset, `start_o` pulses high for exactly one clock. The first pulse comes `START_PERIOD` clocks after reset, and the pulses then repeat every `START_PERIOD` clocks.
- R2: The coarse count is 0 after reset. It is cleared at the clock edge where `start_o` is high, and otherwise increments at every edge. It holds at 2^CW-1 instead of wrapping.
- R3: While the sequencer is idle, a rising edge on `hit_i` sets `stop_o` at once, with no clock involved. `stop_o` then stays high until the re-arm strobe.
- R4: `fine_en_o` is high after reset. It goes low at the first clock edge at which `dl_first_i` is low, and stays low while `dl_first_i` stays low.
- R5: The coarse field of the event is the coarse count during the clock cycle that ends at the edge where `dl_first_i` is first seen low (the capture edge).
- R6: `wr_en_o` goes high for exactly one clock. It rises at the ENC_LAT-th clock edge after the capture edge. `wr_data_o` is {overrange bit at position CW+FW, coarse in bits CW+FW-1:FW, fine_i in bits FW-1:0}, with `fine_i` sampled at that same edge.
- R7: If `fifo_full_i` is high at the edge where the write would occur, `wr_en_o` stays low. `drop_cnt_o` then increments by one, and holds at its maximum value.
- R8: The overrange bit is 1 exactly when the coarse count was at its maximum value during the capture cycle.
- R9: `rearm_o` pulses for one clock, in the cycle that follows the write cycle. This happens whether or not the word was dropped. `rearm_o` clears `stop_o` at once.
- R10: A hit that arrives while the sequencer is not idle (waiting, writing or re-arming) leaves `stop_o` low and produces no FIFO write.
- R11: After reset, `stop_o`, `wr_en_o`, `rearm_o`, `start_o` and `drop_cnt_o` are all 0, and `fine_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_i | input | 1 | Asynchronous detector hit, active on its rising edge |
| dl_first_i | input | 1 | Output of the first delay cell: 1 at rest, falls to 0 when the stop edge enters the line |
| fine_i | input | FW | Fine code from the external encoder |
| fifo_full_i | input | 1 | FIFO full flag |
| start_o | output | 1 | One-clock start pulse |
| stop_o | output | 1 | Stop flag that drives the delay line |
| fine_en_o | output | 1 | Enable for the fine sample register; low freezes the snapshot |
| rearm_o | output | 1 | One-clock re-arm strobe that clears the stop flag |
| wr_en_o | output | 1 | FIFO write enable |
| wr_data_o | output | CW+FW+1 | FIFO write word |
| drop_cnt_o | output | DW | Count of events dropped on a full FIFO, held at its maximum |

## Verification
The bound checker checks the following on every cycle: `start_o`, `wr_en_o` and `rearm_o` are single-cycle pulses; a write never follows a full FIFO; the drop counter only ever steps by one; and the fine enable only ever falls after a low first-cell sample. The bench scenarios are needed for the behaviours that a cycle-local property cannot capture. These are the asynchronous setting of the stop flag, the exact coarse value held relative to the start pulse, the encoder wait length, the overrange flag at saturation, and hits that are ignored while the sequencer is busy.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_WRITE = 2'd2,
    ST_REARM = 2'd3
  } wr_state_t;
endpackage

// File: rtl/tmc_start_gen.sv
module tmc_start_gen #(
  parameter int START_PERIOD = 400,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  output logic          start_o,
  output logic [CW-1:0] count_o,
  output logic          sat_o
);
  localparam int PW = (START_PERIOD > 1) ? $clog2(START_PERIOD) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(START_PERIOD - 1);
  localparam logic [CW-1:0] C_MAX = {CW{1'b1}};

  logic [PW-1:0] per_q;
  logic          start_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q   <= '0;
      start_q <= 1'b0;
    end else begin
      per_q   <= (per_q == P_LAST) ? '0 : per_q + 1'b1;
      start_q <= (per_q == P_LAST);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (start_q)       cnt_q <= '0;
    else if (cnt_q != C_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign start_o = start_q;
  assign count_o = cnt_q;
  assign sat_o   = (cnt_q == C_MAX);
endmodule

// File: rtl/tmc_hit_front.sv
module tmc_hit_front (
  input  logic clk,
  input  logic rst,
  input  logic hit_i,
  input  logic armed_i,
  input  logic rearm_i,
  input  logic dl_first_i,
  output logic stop_o,
  output logic fine_en_o,
  output logic cap_o
);
  logic stop_q;
  logic cell_q;
  logic stop_clr;

  assign stop_clr = rst | rearm_i;

  always_ff @(posedge hit_i or posedge stop_clr) begin
    if (stop_clr)     stop_q <= 1'b0;
    else if (armed_i) stop_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cell_q <= 1'b1;
    else     cell_q <= dl_first_i;
  end

  assign stop_o    = stop_q;
  assign fine_en_o = cell_q;
  assign cap_o     = cell_q & ~dl_first_i;
endmodule

// File: rtl/tmc_wr_fsm.sv
module tmc_wr_fsm
  import tmc_pkg::*;
#(
  parameter int CW = 16,
  parameter int FW = 8,
  parameter int ENC_LAT = 3,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_i,
  input  logic [CW-1:0]    count_i,
  input  logic             sat_i,
  input  logic [FW-1:0]    fine_i,
  input  logic             fifo_full_i,
  output logic             armed_o,
  output logic             rearm_o,
  output logic             wr_en_o,
  output logic [CW+FW:0]   wr_data_o,
  output logic [DW-1:0]    drop_cnt_o
);
  localparam int LW = (ENC_LAT > 1) ? $clog2(ENC_LAT) : 1;
  localparam logic [LW-1:0] L_INIT = LW'(ENC_LAT - 1);
  localparam logic [DW-1:0] D_MAX = {DW{1'b1}};

  wr_state_t      st_q;
  logic [LW-1:0]  wcnt_q;
  logic [CW-1:0]  coarse_q;
  logic           ovr_q;
  logic           wr_q;
  logic [CW+FW:0] data_q;
  logic           rearm_q;
  logic [DW-1:0]  drop_q;
  logic           wr_go;

  assign wr_go = (st_q == ST_WAIT) && (wcnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      wcnt_q   <= '0;
      coarse_q <= '0;
      ovr_q    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (cap_i) begin
          st_q     <= ST_WAIT;
          wcnt_q   <= L_INIT;
          coarse_q <= count_i;
          ovr_q    <= sat_i;
        end
        ST_WAIT: begin
          if (wcnt_q == '0) st_q <= ST_WRITE;
          else              wcnt_q <= wcnt_q - 1'b1;
        end
        ST_WRITE: st_q <= ST_REARM;
        ST_REARM: st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= 1'b0;
      data_q  <= '0;
      rearm_q <= 1'b0;
      drop_q  <= '0;
    end else begin
      wr_q    <= wr_go & ~fifo_full_i;
      rearm_q <= (st_q == ST_WRITE);
      if (wr_go) data_q <= {ovr_q, coarse_q, fine_i};
      if (wr_go && fifo_full_i && drop_q != D_MAX) drop_q <= drop_q + 1'b1;
    end
  end

  assign armed_o    = (st_q == ST_IDLE);
  assign rearm_o    = rearm_q;
  assign wr_en_o    = wr_q;
  assign wr_data_o  = data_q;
  assign drop_cnt_o = drop_q;
endmodule

// File: rtl/tdc_meas_ctrl.sv
module tdc_meas_ctrl #(
  parameter int START_PERIOD = 400,
  parameter int CW = 16,
  parameter int FW = 8,
  parameter int ENC_LAT = 3,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_i,
  input  logic             dl_first_i,
  input  logic [FW-1:0]    fine_i,
  input  logic             fifo_full_i,
  output logic             start_o,
  output logic             stop_o,
  output logic             fine_en_o,
  output logic             rearm_o,
  output logic             wr_en_o,
  output logic [CW+FW:0]   wr_data_o,
  output logic [DW-1:0]    drop_cnt_o
);
  logic [CW-1:0] count;
  logic          sat;
  logic          cap;
  logic          armed;

  tmc_start_gen #(.START_PERIOD(START_PERIOD), .CW(CW)) u_start (
    .clk(clk), .rst(rst), .start_o(start_o), .count_o(count), .sat_o(sat)
  );

  tmc_hit_front u_front (
    .clk(clk), .rst(rst), .hit_i(hit_i), .armed_i(armed), .rearm_i(rearm_o),
    .dl_first_i(dl_first_i), .stop_o(stop_o), .fine_en_o(fine_en_o), .cap_o(cap)
  );

  tmc_wr_fsm #(.CW(CW), .FW(FW), .ENC_LAT(ENC_LAT), .DW(DW)) u_fsm (
    .clk(clk), .rst(rst), .cap_i(cap), .count_i(count), .sat_i(sat),
    .fine_i(fine_i), .fifo_full_i(fifo_full_i), .armed_o(armed),
    .rearm_o(rearm_o), .wr_en_o(wr_en_o), .wr_data_o(wr_data_o),
    .drop_cnt_o(drop_cnt_o)
  );
endmodule

// File: rtl/tdc_meas_ctrl_chk.sv
module tdc_meas_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start_o,
  input logic          wr_en_o,
  input logic          rearm_o,
  input logic          fifo_full_i,
  input logic          fine_en_o,
  input logic          dl_first_i,
  input logic [DW-1:0] drop_cnt_o
);
  // R1
  start_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);
  // R6
  wr_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |=> !wr_en_o);
  // R7
  no_wr_on_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en_o) |-> !$past(fifo_full_i));
  // R7
  drop_step_chk: assert property (@(posedge clk) disable iff (rst)
    (drop_cnt_o != $past(drop_cnt_o)) |-> (drop_cnt_o == $past(drop_cnt_o) + 1'b1));
  // R9
  rearm_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
    rearm_o |=> !rearm_o);
  // R9
  rearm_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |=> rearm_o);
  // R4
  fine_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fine_en_o) |-> !$past(dl_first_i));
endmodule

bind tdc_meas_ctrl tdc_meas_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start_o(start_o), .wr_en_o(wr_en_o),
  .rearm_o(rearm_o), .fifo_full_i(fifo_full_i), .fine_en_o(fine_en_o),
  .dl_first_i(dl_first_i), .drop_cnt_o(drop_cnt_o)
);

// File: tb/tdc_meas_ctrl_bench.sv
`timescale 1ns/1ps
module tdc_meas_ctrl_bench;
  localparam int SP = 400;
  localparam int CW = 8;
  localparam int FW = 8;
  localparam int EL = 3;
  localparam int DW = 8;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hit_i = 1'b0;
  logic dl_first_i;
  logic [FW-1:0] fine_i = '0;
  logic fifo_full_i = 1'b0;
  logic start_o, stop_o, fine_en_o, rearm_o, wr_en_o;
  logic [CW+FW:0] wr_data_o;
  logic [DW-1:0] drop_cnt_o;

  int total = 0;
  int bad = 0;
  logic [CW-1:0] mdl;

  always #2.5 clk = ~clk;
  assign #0.1 dl_first_i = ~stop_o;

  tdc_meas_ctrl #(.START_PERIOD(SP), .CW(CW), .FW(FW), .ENC_LAT(EL), .DW(DW)) u_tdc_meas_ctrl (
    .clk(clk), .rst(rst), .hit_i(hit_i), .dl_first_i(dl_first_i), .fine_i(fine_i),
    .fifo_full_i(fifo_full_i), .start_o(start_o), .stop_o(stop_o),
    .fine_en_o(fine_en_o), .rearm_o(rearm_o), .wr_en_o(wr_en_o),
    .wr_data_o(wr_data_o), .drop_cnt_o(drop_cnt_o)
  );

  // reference coarse count from R2
  always @(posedge clk) begin
    if (rst)              mdl <= '0;
    else if (start_o)     mdl <= '0;
    else if (mdl != CMAX) mdl <= mdl + 1'b1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Hit, then follow one event up to the write; returns nothing, checks inside
  task automatic run_event(input logic [FW-1:0] fv, input bit full, input string tag);
    logic [CW-1:0] ec;
    logic eo;
    logic [DW-1:0] d0;
    fine_i = fv;
    fifo_full_i = full;
    d0 = drop_cnt_o;
    @(negedge clk);
    ec = mdl;
    eo = (mdl == CMAX);
    hit_i = 1'b1;
    #0.5;
    chk(stop_o == 1'b1, {"R3 stop set ", tag}, stop_o, 1);
    hit_i = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(fine_en_o == 1'b0, {"R4 fine freeze ", tag}, fine_en_o, 0);
    for (int i = 1; i < EL; i++) begin
      @(negedge clk);
      chk(wr_en_o == 1'b0 && stop_o == 1'b1, {"R6 wait ", tag}, wr_en_o, 0);
    end
    @(negedge clk);
    if (!full) begin
      chk(wr_en_o == 1'b1, {"R6 write ", tag}, wr_en_o, 1);
      chk(wr_data_o[FW +: CW] == ec, {"R5 coarse ", tag}, wr_data_o[FW +: CW], ec);
      chk(wr_data_o[FW-1:0] == fv, {"R6 fine ", tag}, wr_data_o[FW-1:0], fv);
      chk(wr_data_o[CW+FW] == eo, {"R8 overrange ", tag}, wr_data_o[CW+FW], eo);
    end else begin
      chk(wr_en_o == 1'b0, {"R7 suppressed ", tag}, wr_en_o, 0);
      chk(drop_cnt_o == d0 + 1'b1, {"R7 drop count ", tag}, drop_cnt_o, d0 + 1);
    end
    @(negedge clk);
    chk(rearm_o == 1'b1 && wr_en_o == 1'b0, {"R9 rearm ", tag}, rearm_o, 1);
    chk(stop_o == 1'b0, {"R9 stop cleared ", tag}, stop_o, 0);
    @(negedge clk);
    chk(rearm_o == 1'b0, {"R9 rearm width ", tag}, rearm_o, 0);
    chk(fine_en_o == 1'b1, {"R4 fine release ", tag}, fine_en_o, 1);
    fifo_full_i = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(stop_o == 0 && wr_en_o == 0 && rearm_o == 0 && start_o == 0, "R11 outputs", {stop_o, wr_en_o, rearm_o, start_o}, 0);
    chk(drop_cnt_o == 0 && fine_en_o == 1, "R11 drop/fine_en", {drop_cnt_o, fine_en_o}, 1);
  endtask

  task automatic t_overrange;
    while (mdl != CMAX) @(negedge clk);
    repeat (3) @(negedge clk);
    run_event(8'hA5, 1'b0, "saturated");
  endtask

  task automatic t_normal(input int dly, input logic [FW-1:0] fv, input string tag);
    while (start_o != 1'b1) @(negedge clk);
    repeat (dly) @(negedge clk);
    run_event(fv, 1'b0, tag);
  endtask

  task automatic t_full;
    while (start_o != 1'b1) @(negedge clk);
    repeat (30) @(negedge clk);
    run_event(8'h3C, 1'b1, "full");
    run_event(8'h11, 1'b0, "after full");
  endtask

  task automatic t_ignored;
    // R10: hit during the wait phase and during re-arm
    logic [CW-1:0] ec;
    while (start_o != 1'b1) @(negedge clk);
    repeat (10) @(negedge clk);
    fine_i = 8'h77;
    ec = mdl;
    hit_i = 1'b1; #0.5; hit_i = 1'b0;
    repeat (2) @(negedge clk);
    hit_i = 1'b1; #0.5; hit_i = 1'b0;
    repeat (EL - 1) @(negedge clk);
    chk(wr_en_o == 1'b1 && wr_data_o[FW +: CW] == ec, "R10 first event kept", wr_data_o[FW +: CW], ec);
    @(negedge clk);
    chk(stop_o == 1'b0, "R10 stop cleared", stop_o, 0);
    hit_i = 1'b1; #0.5;
    chk(stop_o == 1'b0, "R10 rearm-phase hit ignored", stop_o, 0);
    hit_i = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(wr_en_o == 1'b0 && stop_o == 1'b0, "R10 no write", {wr_en_o, stop_o}, 0);
    end
  endtask

  task automatic t_start;
    int gap;
    while (start_o != 1'b1) @(negedge clk);
    @(negedge clk);
    chk(start_o == 1'b0, "R1 pulse width", start_o, 0);
    gap = 1;
    while (start_o != 1'b1) begin @(negedge clk); gap++; end
    chk(gap == SP, "R1 period", gap, SP);
    @(negedge clk);
    chk(mdl == 0, "R2 cleared by start", mdl, 0);
    run_event(8'h01, 1'b0, "right after start");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_overrange();
    t_normal(20, 8'h4E, "pattern A");
    t_normal(117, 8'hF0, "pattern B");
    t_full();
    t_ignored();
    t_start();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule